// File: doc/BRIEF.md
# Accumulator Multi-Cycle CPU Core

An 8-bit processor with one accumulator register R, separate program and data memories, and queue-style input and output ports. Each instruction is one opcode byte, and some instructions add an operand byte. A named-state control machine steps each instruction through its phases. It drives the program counter, the instruction register, a small ALU and the data RAM port. The core reads program bytes from a combinational ROM port and data from a combinational RAM port. It takes values from an input queue that shows its head word, and it places results into an output queue.

The control machine has seven states:
- FETCH latches the opcode and advances the PC.
- DECODE either finishes a queue instruction, moves to OPERAND, or moves to HALTED.
- OPERAND latches the second byte and advances the PC again. It moves to DEREF when the instruction is an indirect memory instruction, and to EXECUTE otherwise.
- DEREF reads the effective address from RAM.
- EXECUTE performs the operation. It returns to FETCH, or it enters DELAY for a timed pause.
- DELAY counts down and then returns to FETCH.
- HALTED loops on itself.

Three stall conditions keep the machine in place:
- DECODE stays put when an input instruction finds the input queue empty, or an output instruction finds the output queue full.
- FETCH stays put in single-step mode until a step pulse arrives.
- The hold input freezes the state register and suppresses every strobe.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, `rom_addr` is 0 and `in_pop`, `out_push` and `ram_we` are 0. The first cycle after reset is a FETCH at address 0.
- R2: The opcode's upper nibble selects the operation: 0 input, 1 output, 2 load from memory, 3 store to memory, 4 add, 5 subtract, 6 increment memory, 7 decrement memory, 8 jump, 9 jump if zero, A jump if negative, B load immediate, C delay, F halt. Input, output and halt are one byte long; all other instructions carry an operand byte. The PC advances by 1 for every byte fetched.
- R3: For the memory instructions (upper nibble 2 to 7), opcode bit 3 set selects indirect mode. The byte at RAM[operand] is then the address that the instruction uses.
- R4: Load gives R = M, store writes R to M, add gives R = R + M, subtract gives R = R − M (modulo 256), and load immediate gives R = operand.
- R5: Increment and decrement write M+1 or M−1 (modulo 256) back to the addressed RAM byte and also load that value into R.
- R6: Jump always loads the operand into the PC. Jump-if-zero loads it only when R == 0. Jump-if-negative loads it only when R bit 7 is 1.
- R7: An input instruction facing an empty input queue stays in DECODE without popping. Once data is present, it pops exactly one word into R.
- R8: An output instruction facing a full output queue stays in DECODE without pushing. Once there is space, it pushes R exactly once.
- R9: Timing:
  - A one-byte instruction takes 2 cycles.
  - A two-byte instruction takes 4 cycles.
  - An indirect instruction takes 5 cycles.
  - A delay with operand n adds n × TICKS cycles in DELAY; n = 0 adds none.
- R10: With `dbg_en` high, the core waits in FETCH, with no IR load and no PC change, until `step` is high for a cycle. It then runs exactly one instruction and waits again.
- R11: While `hold` is high, the state does not change and `in_pop`, `out_push` and `ram_we` stay 0. Execution resumes unchanged when `hold` falls.
- R12: Halt, and any undefined upper nibble (D, E), enters HALTED. The PC then never changes and no strobe is raised again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Freeze the control machine |
| dbg_en | input | 1 | Pause before every opcode fetch |
| step | input | 1 | Release one instruction in debug mode |
| rom_addr | output | AW | Program memory address (the PC) |
| rom_data | input | DW | Program byte at `rom_addr`, combinational |
| ram_addr | output | AW | Data memory address |
| ram_wdata | output | DW | Data memory write value |
| ram_we | output | 1 | Data memory write strobe |
| ram_rdata | input | DW | Data byte at `ram_addr`, combinational |
| in_data | input | DW | Head word of the input queue |
| in_empty | input | 1 | Input queue empty |
| in_pop | output | 1 | Consume the head word |
| out_data | output | DW | Value offered to the output queue (R) |
| out_full | input | 1 | Output queue full |
| out_push | output | 1 | Append `out_data` |

## Verification
The bench targets the following corner cases and the faults each one exposes:
- **Queue stalls.** A core that ignored the empty or full flags would pop a non-existent word, or it would lose a result that the bench's queue model never receives.
- **Arithmetic.** A sweep of operand pairs covers wrap-around for add, subtract, increment and decrement. The same sweep covers the jump flags at 0x00, 0x7F, 0x80 and 0xFF. A wrong ALU selection or a wrong sign test shows up as a mismatched output word.
- **Indirect mode.** Indirect loads, stores and increments are checked against the bench RAM. A core that used the operand as the address directly would read and write the wrong byte.
- **Timing and control modes.** The cycle of the first push after a delay is checked exactly, and so are the debug pause, the hold freeze and the halt on undefined opcodes. Any of these would show up as an early push or a moving PC.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        OP_IN   = 4'h0,
        OP_OUT  = 4'h1,
        OP_LDM  = 4'h2,
        OP_STM  = 4'h3,
        OP_ADD  = 4'h4,
        OP_SUB  = 4'h5,
        OP_INC  = 4'h6,
        OP_DEC  = 4'h7,
        OP_JMP  = 4'h8,
        OP_JZ   = 4'h9,
        OP_JN   = 4'hA,
        OP_SET  = 4'hB,
        OP_WAIT = 4'hC,
        OP_HLT  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_OPND,
        S_INDIR,
        S_EXEC,
        S_WAIT,
        S_HALT
    } state_e;

    typedef enum logic [1:0] {
        RS_ALU,
        RS_MEM,
        RS_IN,
        RS_IMM
    } rsrc_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_INC = 2'b10,
        ALU_DEC = 2'b11
    } alu_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mem,
    input  alu_e          op,
    input  logic          flag_neg,
    output logic [DW-1:0] res,
    output logic          flag
);

    always_comb begin
        unique case (op)
            ALU_ADD: res = acc + mem;
            ALU_SUB: res = acc - mem;
            ALU_INC: res = mem + DW'(1);
            ALU_DEC: res = mem - DW'(1);
            default: res = acc;
        endcase
        flag = flag_neg ? acc[DW-1] : (acc == '0);
    end

endmodule

// File: rtl/acc_cpu_pc.sv
module acc_cpu_pc #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          load,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (load) pc <= target;
        else if (inc)  pc <= pc + AW'(1);
    end

    // R2: each fetched byte advances the PC by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (pc == $past(pc) + AW'(1)));

    // R6: a taken branch lands on its operand
    assert_pc_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pc == $past(target)));

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          dbg_en,
    input  logic          step,
    input  logic [DW-1:0] rom_data,
    input  logic [DW-1:0] ram_rdata,
    input  logic          in_empty,
    input  logic          out_full,
    input  logic          alu_flag,
    output logic          pc_inc,
    output logic          pc_load,
    output logic [AW-1:0] pc_target,
    output logic          r_load,
    output rsrc_e         r_src,
    output logic [DW-1:0] imm,
    output alu_e          alu_op,
    output logic          flag_neg,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          wsel_acc,
    output logic          in_pop,
    output logic          out_push
);

    localparam int CW = DW + $clog2(TICKS + 1);

    state_e         state_q, state_d;
    op_e            op_q;
    logic           ind_q;
    logic [DW-1:0]  opnd_q;
    logic [AW-1:0]  eff_q;
    logic [CW-1:0]  cnt_q;
    logic           ir_ld, opnd_ld, eff_ld, cnt_ld, cnt_dec;
    logic           mem_op;

    assign mem_op    = op_q inside {OP_LDM, OP_STM, OP_ADD, OP_SUB, OP_INC, OP_DEC};
    assign imm       = opnd_q;
    assign pc_target = AW'(opnd_q);
    assign ram_addr  = (state_q == S_INDIR) ? AW'(opnd_q) : eff_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // instruction, operand, address and delay registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IN;
            ind_q  <= 1'b0;
            opnd_q <= '0;
            eff_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (ir_ld) begin
                op_q  <= op_e'(rom_data[DW-1:DW-4]);
                ind_q <= rom_data[3];
            end
            if (opnd_ld) begin
                opnd_q <= rom_data;
                eff_q  <= AW'(rom_data);
            end
            if (eff_ld) eff_q <= AW'(ram_rdata);
            if (cnt_ld)       cnt_q <= CW'(opnd_q) * CW'(TICKS);
            else if (cnt_dec) cnt_q <= cnt_q - CW'(1);
        end
    end

    // next state and control outputs
    always_comb begin
        state_d  = state_q;
        ir_ld    = 1'b0;
        opnd_ld  = 1'b0;
        eff_ld   = 1'b0;
        cnt_ld   = 1'b0;
        cnt_dec  = 1'b0;
        pc_inc   = 1'b0;
        pc_load  = 1'b0;
        r_load   = 1'b0;
        r_src    = RS_ALU;
        alu_op   = ALU_ADD;
        flag_neg = 1'b0;
        ram_we   = 1'b0;
        wsel_acc = 1'b0;
        in_pop   = 1'b0;
        out_push = 1'b0;

        unique case (state_q)
            S_FETCH: begin
                if (!dbg_en || step) begin
                    ir_ld   = 1'b1;
                    pc_inc  = 1'b1;
                    state_d = S_DECODE;
                end
            end
            S_DECODE: begin
                case (op_q)
                    OP_IN: if (!in_empty) begin
                        in_pop  = 1'b1;
                        r_load  = 1'b1;
                        r_src   = RS_IN;
                        state_d = S_FETCH;
                    end
                    OP_OUT: if (!out_full) begin
                        out_push = 1'b1;
                        state_d  = S_FETCH;
                    end
                    OP_LDM, OP_STM, OP_ADD, OP_SUB, OP_INC, OP_DEC,
                    OP_JMP, OP_JZ, OP_JN, OP_SET, OP_WAIT:
                        state_d = S_OPND;
                    default: state_d = S_HALT;
                endcase
            end
            S_OPND: begin
                pc_inc  = 1'b1;
                opnd_ld = 1'b1;
                state_d = (mem_op && ind_q) ? S_INDIR : S_EXEC;
            end
            S_INDIR: begin
                eff_ld  = 1'b1;
                state_d = S_EXEC;
            end
            S_EXEC: begin
                state_d = S_FETCH;
                case (op_q)
                    OP_LDM: begin r_load = 1'b1; r_src = RS_MEM; end
                    OP_STM: begin ram_we = 1'b1; wsel_acc = 1'b1; end
                    OP_ADD: begin r_load = 1'b1; alu_op = ALU_ADD; end
                    OP_SUB: begin r_load = 1'b1; alu_op = ALU_SUB; end
                    OP_INC: begin r_load = 1'b1; alu_op = ALU_INC; ram_we = 1'b1; end
                    OP_DEC: begin r_load = 1'b1; alu_op = ALU_DEC; ram_we = 1'b1; end
                    OP_JMP: pc_load = 1'b1;
                    OP_JZ:  begin flag_neg = 1'b0; pc_load = alu_flag; end
                    OP_JN:  begin flag_neg = 1'b1; pc_load = alu_flag; end
                    OP_SET: begin r_load = 1'b1; r_src = RS_IMM; end
                    OP_WAIT: if (opnd_q != '0) begin
                        cnt_ld  = 1'b1;
                        state_d = S_WAIT;
                    end
                    default: ;
                endcase
            end
            S_WAIT: begin
                cnt_dec = 1'b1;
                if (cnt_q == CW'(1)) state_d = S_FETCH;
            end
            S_HALT: state_d = S_HALT;
            default: state_d = S_HALT;
        endcase

        if (hold) begin
            state_d  = state_q;
            ir_ld    = 1'b0;
            opnd_ld  = 1'b0;
            eff_ld   = 1'b0;
            cnt_ld   = 1'b0;
            cnt_dec  = 1'b0;
            pc_inc   = 1'b0;
            pc_load  = 1'b0;
            r_load   = 1'b0;
            ram_we   = 1'b0;
            in_pop   = 1'b0;
            out_push = 1'b0;
        end
    end

    // R7: an empty input queue keeps an input instruction in DECODE
    assert_inbox_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE && op_q == OP_IN && in_empty) |=> (state_q == S_DECODE));

    // R8: a full output queue keeps an output instruction in DECODE
    assert_outbox_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE && op_q == OP_OUT && out_full) |=> (state_q == S_DECODE));

    // R8: never push into a full queue
    assert_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> !out_full);

    // R10: debug mode parks in FETCH until a step pulse
    assert_dbg_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && dbg_en && !step && !hold) |=> (state_q == S_FETCH && $stable(op_q)));

    // R11: hold freezes the machine
    assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(state_q) && $stable(op_q) && $stable(opnd_q)));

    // R12: halted is terminal
    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (state_q == S_HALT));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          dbg_en,
    input  logic          step,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    input  logic [DW-1:0] ram_rdata,
    input  logic [DW-1:0] in_data,
    input  logic          in_empty,
    output logic          in_pop,
    output logic [DW-1:0] out_data,
    input  logic          out_full,
    output logic          out_push
);

    logic          pc_inc, pc_load, r_load, flag_neg, alu_flag, wsel_acc;
    logic [AW-1:0] pc_target;
    logic [DW-1:0] imm, alu_res, r_q;
    rsrc_e         r_src;
    alu_e          alu_op;

    acc_cpu_ctrl #(.DW(DW), .AW(AW), .TICKS(TICKS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .dbg_en    (dbg_en),
        .step      (step),
        .rom_data  (rom_data),
        .ram_rdata (ram_rdata),
        .in_empty  (in_empty),
        .out_full  (out_full),
        .alu_flag  (alu_flag),
        .pc_inc    (pc_inc),
        .pc_load   (pc_load),
        .pc_target (pc_target),
        .r_load    (r_load),
        .r_src     (r_src),
        .imm       (imm),
        .alu_op    (alu_op),
        .flag_neg  (flag_neg),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .wsel_acc  (wsel_acc),
        .in_pop    (in_pop),
        .out_push  (out_push)
    );

    acc_cpu_pc #(.AW(AW)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (pc_inc),
        .load   (pc_load),
        .target (pc_target),
        .pc     (rom_addr)
    );

    acc_cpu_alu #(.DW(DW)) u_alu (
        .acc      (r_q),
        .mem      (ram_rdata),
        .op       (alu_op),
        .flag_neg (flag_neg),
        .res      (alu_res),
        .flag     (alu_flag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else if (r_load) begin
            unique case (r_src)
                RS_ALU:  r_q <= alu_res;
                RS_MEM:  r_q <= ram_rdata;
                RS_IN:   r_q <= in_data;
                RS_IMM:  r_q <= imm;
                default: r_q <= r_q;
            endcase
        end
    end

    assign ram_wdata = wsel_acc ? r_q : alu_res;
    assign out_data  = r_q;

    // R7: a pop captures the queue head into R
    assert_pop_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |=> (out_data == $past(in_data)));

    // R1/R11: no strobe during hold
    assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(in_pop || out_push || ram_we));

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    localparam int TK = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold = 1'b0, dbg_en = 1'b0, step = 1'b0, out_full = 1'b0;
    logic [7:0] rom_addr, rom_data, ram_addr, ram_wdata, ram_rdata;
    logic [7:0] in_data, out_data;
    logic       ram_we, in_empty, in_pop, out_push;

    always #10 clk = ~clk;

    acc_cpu #(.DW(8), .AW(8), .TICKS(TK)) u_dut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .dbg_en(dbg_en), .step(step),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .in_data(in_data), .in_empty(in_empty), .in_pop(in_pop),
        .out_data(out_data), .out_full(out_full), .out_push(out_push)
    );

    logic [7:0] rom [256];
    logic [7:0] ram [256];
    logic [7:0] inq [2048];
    logic [7:0] outq [2048];
    int in_rd, in_wr, out_n, cyc;
    int total = 0, bad = 0;
    logic [7:0] prg [$];

    assign rom_data  = rom[rom_addr];
    assign ram_rdata = ram[ram_addr];
    assign in_data   = inq[in_rd];
    assign in_empty  = (in_rd == in_wr);

    always @(posedge clk) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        if (in_pop) in_rd <= in_rd + 1;
        if (out_push) begin
            outq[out_n] <= out_data;
            out_n <= out_n + 1;
        end
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_in(input logic [7:0] v);
        inq[in_wr] = v;
        in_wr++;
    endtask

    task automatic restart(input bit dbg);
        @(negedge clk);
        rst_n = 1'b0;
        hold = 1'b0; step = 1'b0; out_full = 1'b0; dbg_en = dbg;
        for (int i = 0; i < 256; i++) begin
            rom[i] = 8'hF0;
            ram[i] = 8'(i) ^ 8'h5A;
        end
        foreach (prg[i]) rom[i] = prg[i];
        in_rd = 0; in_wr = 0; out_n = 0;
        ticks(2);
        // R1: reset state
        chk("R1 rom_addr in reset", int'(rom_addr), 0);
        chk("R1 strobes in reset", int'({in_pop, out_push, ram_we}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_outs(input string req, input int target, input int limit);
        int k = 0;
        while (out_n < target && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk(req, out_n, target);
    endtask

    task automatic pulse_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        logic [7:0] sw [10];
        logic [7:0] bl [16];
        logic [7:0] a, b, cls, p, v, init;
        int base, ra, ir0, on0, k, pc_at;
        bit strobe, seen;

        // ---------- swap-pairs program, stalls and hold ----------
        prg = '{8'h00, 8'h30, 8'h02, 8'h00, 8'h10, 8'h20, 8'h02, 8'h10, 8'h80, 8'h00};
        sw = '{8'h03, 8'h09, 8'h5A, 8'h48, 8'h02, 8'h07, 8'h80, 8'hFF, 8'h11, 8'h00};
        restart(1'b0);
        out_full = 1'b1;
        for (int i = 0; i < 8; i++) push_in(sw[i]);
        ticks(60);
        chk("R8 no push while full", out_n, 0);
        chk("R8 pops before stall", in_rd, 2);
        out_full = 1'b0;
        ticks(5);
        hold = 1'b1;
        ra = int'(rom_addr); ir0 = in_rd; on0 = out_n; strobe = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (in_pop || out_push || ram_we) strobe = 1'b1;
        end
        chk("R11 pc frozen", int'(rom_addr), ra);
        chk("R11 pops frozen", in_rd, ir0);
        chk("R11 pushes frozen", out_n, on0);
        chk("R11 strobes quiet", int'(strobe), 0);
        hold = 1'b0;
        run_outs("R7 swap progress", 8, 400);
        for (int i = 0; i < 8; i++)
            chk("R7 swap order", int'(outq[i]), int'(sw[i ^ 1]));
        ticks(40);
        chk("R7 no pop while empty", in_rd, 8);
        chk("R7 no output while starved", out_n, 8);
        push_in(sw[8]); push_in(sw[9]);
        run_outs("R7 resume after data", 10, 200);
        chk("R7 resumed pair hi", int'(outq[8]), int'(sw[9]));
        chk("R7 resumed pair lo", int'(outq[9]), int'(sw[8]));

        // ---------- ALU / jump sweep ----------
        prg = '{8'h00, 8'h30, 8'h00, 8'h00, 8'h30, 8'h01, 8'h40, 8'h00, 8'h10,
                8'h20, 8'h01, 8'h50, 8'h00, 8'h10, 8'h60, 8'h00, 8'h10, 8'h70, 8'h00, 8'h10,
                8'h20, 8'h01, 8'hA0, 8'h1E, 8'h90, 8'h22, 8'hB0, 8'h01, 8'h80, 8'h24,
                8'hB0, 8'h02, 8'h80, 8'h24, 8'hB0, 8'h03, 8'h10, 8'h80, 8'h00};
        bl = '{8'h00, 8'h01, 8'h02, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hFE,
               8'hFF, 8'h40, 8'h33, 8'hC0, 8'h10, 8'h55, 8'hAA, 8'h01};
        restart(1'b0);
        for (int ai = 0; ai < 256; ai += 15) begin
            for (int bi = 0; bi < 16; bi++) begin
                a = 8'(ai); b = bl[bi];
                base = out_n;
                push_in(a); push_in(b);
                run_outs("R2 sweep progress", base + 5, 500);
                cls = b[7] ? 8'd2 : ((b == 8'd0) ? 8'd3 : 8'd1);
                chk("R4 add", int'(outq[base]), int'(8'(b + a)));
                chk("R4 sub", int'(outq[base + 1]), int'(8'(b - a)));
                chk("R5 bump up", int'(outq[base + 2]), int'(8'(a + 8'd1)));
                chk("R5 bump down", int'(outq[base + 3]), int'(a));
                chk("R6 branch class", int'(outq[base + 4]), int'(cls));
            end
        end

        // ---------- indirect addressing ----------
        prg = '{8'h00, 8'h30, 8'h05, 8'h28, 8'h05, 8'h10, 8'h00, 8'h38, 8'h05,
                8'h68, 8'h05, 8'h10, 8'h80, 8'h00};
        restart(1'b0);
        for (int j = 0; j < 6; j++) begin
            p = (j == 0) ? 8'h00 : ((j == 1) ? 8'hFF : 8'(8'h10 + 8'(j * 37)));
            v = 8'(j * 53 + 8'hF0);
            init = p ^ 8'h5A;
            base = out_n;
            push_in(p); push_in(v);
            run_outs("R3 indirect progress", base + 2, 200);
            chk("R3 indirect load", int'(outq[base]), int'(init));
            chk("R5 indirect bump result", int'(outq[base + 1]), int'(8'(v + 8'd1)));
            chk("R3 indirect store target", int'(ram[p]), int'(8'(v + 8'd1)));
            chk("R3 pointer cell", int'(ram[5]), int'(p));
        end

        // ---------- delay timing and halt ----------
        prg = '{8'hC0, 8'h03, 8'hB0, 8'h77, 8'h10, 8'hF0};
        restart(1'b0);
        seen = 1'b0; pc_at = -1; k = 0;
        while (!seen && k < 300) begin
            @(negedge clk);
            k++;
            if (out_push) begin seen = 1'b1; pc_at = cyc; end
        end
        chk("R9 delayed push cycle", pc_at, 9 + 3 * TK);
        ticks(40);
        chk("R9 delayed value", int'(outq[0]), 8'h77);
        chk("R12 halt pc", int'(rom_addr), 6);
        chk("R12 halt no push", out_n, 1);

        prg = '{8'hC0, 8'h00, 8'hB0, 8'h55, 8'h10, 8'hF0};
        restart(1'b0);
        seen = 1'b0; pc_at = -1; k = 0;
        while (!seen && k < 300) begin
            @(negedge clk);
            k++;
            if (out_push) begin seen = 1'b1; pc_at = cyc; end
        end
        chk("R9 zero delay push cycle", pc_at, 9);

        prg = '{8'hD0, 8'h10, 8'h10};
        restart(1'b0);
        ticks(30);
        chk("R12 undefined opcode pc", int'(rom_addr), 1);
        chk("R12 undefined opcode no push", out_n, 0);

        // ---------- debug stepping ----------
        prg = '{8'hB0, 8'h11, 8'h10, 8'hB0, 8'h22, 8'h10, 8'hF0};
        restart(1'b1);
        ticks(20);
        chk("R10 parked pc", int'(rom_addr), 0);
        pulse_step();
        ticks(20);
        chk("R10 one instruction pc", int'(rom_addr), 2);
        chk("R10 no output yet", out_n, 0);
        pulse_step();
        ticks(20);
        chk("R10 second step output", out_n, 1);
        chk("R10 second step value", int'(outq[0]), 8'h11);
        chk("R10 second step pc", int'(rom_addr), 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule